// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block turns an encoded interrupt request level into the hardware part of exception entry. It keeps a 16-bit status word holding a trace field, a supervisor flag, a master/interrupt flag and a 3-bit priority mask. When a request is strong enough it saves the old status word, raises privilege, stops tracing and moves the mask up to the serviced level. It then writes a four-word exception record through a 16-bit word-write port that waits on a ready handshake. Finally it pulses a handler-start strobe together with the autovector number.

Two stack pointers are kept: a master stack pointer and an interrupt stack pointer. The master/interrupt flag decides which one is active. An outermost interrupt is one taken while the flag is set. For such an interrupt the block writes the record on the master stack, clears the flag, and writes a second copy on the interrupt stack, which then becomes active. A nested interrupt, taken with the flag already clear, writes one record on the interrupt stack, and the active stack stays the same. Level 7 cannot be masked. It is taken once for each rise of the request to 7. The core's execution path can overwrite the status word through a load port while the sequencer is idle.

The controller is a four-state machine. In IDLE it waits for a request. On the transition IDLE→PUSH (accept) it latches the level and PC and updates the status word. In PUSH it writes one record word per ready cycle. The transition PUSH→SWITCH (outer copy) follows the last word of a master-stack record. The transition PUSH→NOTIFY (record done) follows the last word of the final record. The transition SWITCH→PUSH (second record) moves the write base to the interrupt stack. In NOTIFY the strobe is raised, and NOTIFY→IDLE (return) follows on the next cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the status word is 0x2700 (trace 00 in bits 15:14, supervisor bit 13 set, master bit 12 clear, mask bits 10:8 = 7). The sequencer is idle, no write is issued, and the active stack pointer equals the interrupt stack pointer's reset value.
- R2: A request level that is less than or equal to the mask in bits 10:8 is ignored: no write, no strobe, and the status word and active stack pointer are unchanged. Level 0 never causes an entry.
- R3: Level 7 is accepted even when the mask is 7. A level-7 request held steady causes exactly one entry, and each new rise to 7 causes another one.
- R4: On acceptance the new status word has bits 15:14 = 00, bit 13 = 1, bit 12 = 0, bits 10:8 = serviced level, and bit 11 and bits 7:0 kept. The first record word is the status word as it was before acceptance.
- R5: A record is written at addresses base+0, +2, +4, +6 with the words status, PC[31:16], PC[15:0] and format/vector word. The base is the chosen stack pointer minus 8, and that pointer keeps the decremented value.
- R6: The format/vector word has bits 15:12 = 0 and bits 11:0 = vector × 4. The vector is 24 + level.
- R7: If bit 12 was set at acceptance, the record goes to the master stack and a second identical record goes to the interrupt stack, 8 writes in all. Otherwise one record goes to the interrupt stack. Afterwards the active stack pointer is the interrupt stack pointer.
- R8: Each write stays asserted, with address and data stable, until mem_rdy is sampled high, and each word is written exactly once.
- R9: After the last write, handler_start is high for exactly one cycle, and vec_num then equals 24 + the serviced level.
- R10: sr_load while idle replaces the status word on the next edge. No request is accepted in the cycle of a load; the request is judged against the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level | input | 3 | Encoded request level, 0 = none |
| pc_in | input | 32 | Program counter to save, sampled at acceptance |
| sr_load | input | 1 | Load the status word (honoured when idle) |
| sr_load_val | input | 16 | Value for sr_load |
| mem_rdy | input | 1 | Write accepted in this cycle |
| mem_we | output | 1 | Word write request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Word to write |
| sr_out | output | 16 | Current status word |
| active_sp | output | ADDR_W | Stack pointer chosen by the master bit |
| busy | output | 1 | Entry in progress |
| handler_start | output | 1 | One-cycle handler start strobe |
| vec_num | output | 8 | Vector number of the last entry |

## Verification
The hardest path to reach is the outermost entry. It needs the master bit set, and reset leaves that bit clear. No entry ever sets it again, so every accepted interrupt would otherwise be nested. Each stimulus vector therefore first loads a chosen status word through the load port and only then raises the request. This reaches outermost, nested, trace-set and user-mode starting points. One directed case drives the load and the request in the same cycle, to show that the load wins. Another holds level 7 for many cycles to show a single entry. A third toggles mem_rdy to stretch every write.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int LVL_W       = 3;
    localparam int WORD_W      = 16;
    localparam int PC_W        = 2 * WORD_W;
    localparam int FRAME_WORDS = 4;
    localparam int FRAME_BYTES = FRAME_WORDS * (WORD_W / 8);
    localparam int IDX_W       = $clog2(FRAME_WORDS);

    localparam int SR_T_HI  = 15;
    localparam int SR_T_LO  = 14;
    localparam int SR_S     = 13;
    localparam int SR_M     = 12;
    localparam int SR_MK_HI = 10;
    localparam int SR_MK_LO = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_SWITCH,
        ST_NOTIFY
    } seq_state_e;
endpackage

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] mask,
    input  logic             idle,
    input  logic             hold,
    output logic             take,
    output logic [LVL_W-1:0] take_lvl
);
    localparam logic [LVL_W-1:0] TOP = '1;

    logic prev_top;
    logic nmi_pend;
    logic at_top;
    logic top_edge;

    assign at_top   = (level == TOP);
    assign top_edge = at_top && !prev_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_top <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            prev_top <= at_top;
            if (top_edge)
                nmi_pend <= 1'b1;
            else if (take && nmi_pend)
                nmi_pend <= 1'b0;
        end
    end

    assign take     = idle && !hold && (nmi_pend || (!at_top && (level > mask)));
    assign take_lvl = nmi_pend ? TOP : level;

    // R3: a served top-level request is consumed, so a held level gives one entry
    p_nmi_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && nmi_pend && !top_edge) |=> !nmi_pend);
endmodule

// File: rtl/irq_frame_words.sv
module irq_frame_words
    import irq_entry_pkg::*;
(
    input  logic [WORD_W-1:0] saved_sr,
    input  logic [PC_W-1:0]   pc,
    input  logic [7:0]        vec,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] fvo;

    assign fvo = {4'h0, 2'b00, vec, 2'b00};

    always_comb begin
        unique case (idx)
            2'd0:    word = saved_sr;
            2'd1:    word = pc[PC_W-1:WORD_W];
            2'd2:    word = pc[WORD_W-1:0];
            default: word = fvo;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] MSP_INIT = 'h1000,
    parameter logic [ADDR_W-1:0] ISP_INIT = 'h2000,
    parameter int              VEC_BASE = 24,
    parameter logic [15:0]     SR_INIT  = 16'h2700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        irq_level,
    input  logic [31:0]       pc_in,
    input  logic              sr_load,
    input  logic [15:0]       sr_load_val,
    input  logic              mem_rdy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic [15:0]       sr_out,
    output logic [ADDR_W-1:0] active_sp,
    output logic              busy,
    output logic              handler_start,
    output logic [7:0]        vec_num
);
    localparam logic [ADDR_W-1:0] FRAME_B = ADDR_W'(FRAME_BYTES);
    localparam logic [7:0]        VB      = 8'(VEC_BASE);
    localparam logic [IDX_W-1:0]  LAST    = IDX_W'(FRAME_WORDS - 1);

    seq_state_e state, nxt;

    logic [WORD_W-1:0] sr, saved_sr;
    logic [ADDR_W-1:0] msp, isp, base;
    logic [PC_W-1:0]   pc_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [IDX_W-1:0]  idx;
    logic              second;
    logic              take;
    logic [LVL_W-1:0]  take_lvl;
    logic              idle_w;
    logic [WORD_W-1:0] word;

    assign idle_w  = (state == ST_IDLE);
    assign vec_num = VB + {5'd0, lvl_q};

    irq_level_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (irq_level),
        .mask     (sr[SR_MK_HI:SR_MK_LO]),
        .idle     (idle_w),
        .hold     (sr_load),
        .take     (take),
        .take_lvl (take_lvl)
    );

    irq_frame_words u_words (
        .saved_sr (saved_sr),
        .pc       (pc_q),
        .vec      (vec_num),
        .idx      (idx),
        .word     (word)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (take) nxt = ST_PUSH;
            ST_PUSH:   if (mem_rdy && idx == LAST) nxt = second ? ST_SWITCH : ST_NOTIFY;
            ST_SWITCH: nxt = ST_PUSH;
            ST_NOTIFY: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= SR_INIT;
            saved_sr <= '0;
            msp      <= MSP_INIT;
            isp      <= ISP_INIT;
            base     <= '0;
            pc_q     <= '0;
            lvl_q    <= '0;
            idx      <= '0;
            second   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sr_load) begin
                        sr <= sr_load_val;
                    end else if (take) begin
                        saved_sr <= sr;
                        pc_q     <= pc_in;
                        lvl_q    <= take_lvl;
                        sr       <= {2'b00, 1'b1, 1'b0, sr[11], take_lvl, sr[7:0]};
                        idx      <= '0;
                        if (sr[SR_M]) begin
                            msp    <= msp - FRAME_B;
                            base   <= msp - FRAME_B;
                            second <= 1'b1;
                        end else begin
                            isp    <= isp - FRAME_B;
                            base   <= isp - FRAME_B;
                            second <= 1'b0;
                        end
                    end
                end
                ST_PUSH: begin
                    if (mem_rdy) idx <= idx + 1'b1;
                end
                ST_SWITCH: begin
                    isp    <= isp - FRAME_B;
                    base   <= isp - FRAME_B;
                    second <= 1'b0;
                    idx    <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we        = (state == ST_PUSH);
        mem_addr      = base + {{(ADDR_W-IDX_W-1){1'b0}}, idx, 1'b0};
        mem_wdata     = word;
        handler_start = (state == ST_NOTIFY);
        busy          = !idle_w;
        sr_out        = sr;
        active_sp     = sr[SR_M] ? msp : isp;
    end

    // R8: a stalled write keeps its address and data
    p_write_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_rdy) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R9: the start strobe lasts one cycle
    p_start_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |=> !handler_start);

    // R4: acceptance raises privilege, clears trace and master, loads the mask
    p_entry_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_w && take) |=> (sr[SR_S] && !sr[SR_M] && sr[SR_T_HI:SR_T_LO] == 2'b00
                              && sr[SR_MK_HI:SR_MK_LO] == lvl_q && saved_sr == $past(sr)));

    // R7: the second record is only written for an entry from master state
    p_copy_only_outer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCH) |-> saved_sr[SR_M]);
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    localparam logic [31:0] MSP0 = 32'h1000;
    localparam logic [31:0] ISP0 = 32'h2000;
    localparam int NV = 7;
    // {status, level, pc, accepted}
    localparam logic [51:0] TBL [NV] = '{
        {16'h3000, 3'd3, 32'h0001_2344, 1'b1},
        {16'h2300, 3'd5, 32'h0002_0010, 1'b1},
        {16'h2500, 3'd5, 32'h0003_0000, 1'b0},
        {16'h2500, 3'd2, 32'h0004_0000, 1'b0},
        {16'h2700, 3'd7, 32'h00AB_CDEF, 1'b1},
        {16'hF400, 3'd6, 32'h1234_5678, 1'b1},
        {16'h1000, 3'd1, 32'hFFFF_FFFE, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [2:0] irq_level;
    logic [31:0] pc_in;
    logic sr_load;
    logic [15:0] sr_val;
    logic rdy;
    logic mem_we, busy, handler_start;
    logic [31:0] mem_addr, active_sp;
    logic [15:0] mem_wdata, sr_out;
    logic [7:0] vec_num;

    always #2.5 clk = ~clk;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .pc_in(pc_in),
        .sr_load(sr_load), .sr_load_val(sr_val), .mem_rdy(rdy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .sr_out(sr_out), .active_sp(active_sp), .busy(busy),
        .handler_start(handler_start), .vec_num(vec_num)
    );

    int errors = 0;
    int checks = 0;
    logic stall_mode = 1'b0;
    logic [31:0] log_a [256];
    logic [15:0] log_d [256];
    int n_w = 0;
    int n_s = 0;
    int dbl = 0;
    logic prev_hs = 1'b0;
    logic [7:0] last_vec;
    logic [31:0] msp_m, isp_m;

    // memory side: ready pattern, write log, strobe log
    always @(negedge clk) begin
        if (!rst_n) rdy = 1'b1;
        else if (stall_mode) rdy = ~rdy;
        else rdy = 1'b1;
        if (rst_n && mem_we && rdy) begin
            log_a[n_w % 256] = mem_addr;
            log_d[n_w % 256] = mem_wdata;
            n_w = n_w + 1;
        end
        if (rst_n && handler_start) begin
            n_s = n_s + 1;
            last_vec = vec_num;
            if (prev_hs) dbl = dbl + 1;
        end
        prev_hs = handler_start;
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int k, input logic [15:0] s,
                                             input logic [31:0] p, input logic [2:0] l);
        case (k)
            0: return s;
            1: return p[31:16];
            2: return p[15:0];
            default: return {4'h0, 2'b00, 8'(24 + l), 2'b00};
        endcase
    endfunction

    task automatic run(input logic [15:0] s, input logic [2:0] l, input logic [31:0] p,
                       input logic acc, input logic stl, input logic simul);
        int w0, s0, nexp;
        logic [31:0] b1, b2;
        stall_mode = stl;
        if (!simul) begin
            @(negedge clk); sr_load = 1'b1; sr_val = s;
            @(negedge clk); sr_load = 1'b0;
            w0 = n_w; s0 = n_s;
            irq_level = l; pc_in = p;
        end else begin
            w0 = n_w; s0 = n_s;
            @(negedge clk); sr_load = 1'b1; sr_val = s; irq_level = l; pc_in = p;
            @(negedge clk); sr_load = 1'b0;
            chk(sr_out == s && !busy, "R10 load wins over same-cycle request", {16'h0, sr_out}, {16'h0, s});
        end
        if (acc) begin
            for (int i = 0; i < 100 && n_s == s0; i++) @(negedge clk);
        end else begin
            repeat (12) @(negedge clk);
        end
        irq_level = 3'd0;
        @(negedge clk);
        if (acc) begin
            if (s[12]) begin
                msp_m = msp_m - 8; b1 = msp_m;
                isp_m = isp_m - 8; b2 = isp_m; nexp = 8;
            end else begin
                isp_m = isp_m - 8; b1 = isp_m; b2 = isp_m; nexp = 4;
            end
            chk(n_w - w0 == nexp, "R7 R8 number of record writes", n_w - w0, nexp);
            for (int k = 0; k < nexp && k < n_w - w0; k++) begin
                chk(log_a[(w0 + k) % 256] == ((k < 4 ? b1 : b2) + 32'(2 * (k % 4))),
                    "R5 R7 record address", log_a[(w0 + k) % 256], (k < 4 ? b1 : b2) + 32'(2 * (k % 4)));
                chk(log_d[(w0 + k) % 256] == exp_word(k % 4, s, p, l),
                    "R5 R6 record word", {16'h0, log_d[(w0 + k) % 256]}, {16'h0, exp_word(k % 4, s, p, l)});
            end
            chk(n_s - s0 == 1, "R9 one start strobe", n_s - s0, 1);
            chk(last_vec == 8'(24 + l), "R9 vector number", {24'h0, last_vec}, 32'(24 + l));
            chk(sr_out == {2'b00, 1'b1, 1'b0, s[11], l, s[7:0]}, "R4 status after entry",
                {16'h0, sr_out}, {16'h0, 2'b00, 1'b1, 1'b0, s[11], l, s[7:0]});
            chk(active_sp == isp_m, "R7 active stack after entry", active_sp, isp_m);
            chk(!busy, "R9 idle after entry", {31'h0, busy}, 0);
        end else begin
            chk(n_w == w0, "R2 no write for masked level", n_w - w0, 0);
            chk(n_s == s0, "R2 no strobe for masked level", n_s - s0, 0);
            chk(sr_out == s, "R2 status unchanged", {16'h0, sr_out}, {16'h0, s});
            chk(active_sp == (s[12] ? msp_m : isp_m), "R2 stack unchanged", active_sp, s[12] ? msp_m : isp_m);
        end
    endtask

    initial begin
        rst_n = 1'b0; irq_level = 3'd0; pc_in = 32'h0; sr_load = 1'b0; sr_val = 16'h0;
        msp_m = MSP0; isp_m = ISP0;
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                chk(sr_out == 16'h2700, "R1 reset status", {16'h0, sr_out}, 32'h2700);
                chk(active_sp == ISP0, "R1 reset active stack", active_sp, ISP0);
                chk(!busy && !mem_we && !handler_start, "R1 reset idle",
                    {29'h0, busy, mem_we, handler_start}, 0);

                for (int v = 0; v < NV; v++)
                    run(TBL[v][51:36], TBL[v][35:33], TBL[v][32:1], TBL[v][0], 1'b0, 1'b0);

                // R3: level 7 held steady gives one entry, a new rise gives another
                begin
                    int w0, s0;
                    @(negedge clk); sr_load = 1'b1; sr_val = 16'h2700;
                    @(negedge clk); sr_load = 1'b0;
                    w0 = n_w; s0 = n_s;
                    irq_level = 3'd7; pc_in = 32'h0000_7777;
                    repeat (40) @(negedge clk);
                    isp_m = isp_m - 8;
                    chk(n_s - s0 == 1, "R3 held level 7 enters once", n_s - s0, 1);
                    chk(n_w - w0 == 4, "R3 held level 7 writes one record", n_w - w0, 4);
                    irq_level = 3'd0;
                    repeat (3) @(negedge clk);
                    irq_level = 3'd7;
                    repeat (20) @(negedge clk);
                    isp_m = isp_m - 8;
                    chk(n_s - s0 == 2, "R3 new rise to 7 enters again", n_s - s0, 2);
                    chk(active_sp == isp_m, "R3 stack after second level-7 entry", active_sp, isp_m);
                    irq_level = 3'd0;
                    repeat (2) @(negedge clk);
                end

                // R8: stretched writes
                run(16'h2000, 3'd2, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
                stall_mode = 1'b0;
                // R10: load and request in the same cycle
                run(16'h3000, 3'd4, 32'h0BAD_F00D, 1'b1, 1'b0, 1'b1);

                chk(dbl == 0, "R9 strobe never two cycles", dbl, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired R9 entry never completed actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule